// File: doc/BRIEF.md
# Thermal Migration Trigger

This block decides, from the temperature samples of the active core of a rotating group of cores, when execution must move to the next core and when the current core must be throttled. A sensor delivers a temperature sample with a one-cycle valid strobe, once per sensor period. A `tick` input counts core cycles. The block keeps an elapsed-time counter that starts again each time a migration completes.

A sample above the programmable limit starts a migration. If enough time has passed since the last migration, the block raises the migration request at once. If not enough time has passed, the block schedules the migration for the moment the elapsed counter reaches the minimum interval, and stops the core until then. Each further over-limit sample keeps the core stopped for one more sensor period. The request stays high until the migration sequencer acknowledges completion.

Top module: `mig_thermal_trigger`

## Requirements
- R1: After reset, `mig_req` and `stop` are low and the elapsed counter is zero. A reset therefore counts as a migration that has just completed.
- R2: In the running mode, a sample that is not strictly greater than `temp_limit` raises neither `mig_req` nor `stop`. A sample equal to the limit counts as not over.
- R3: In the running mode, an over-limit sample taken while the elapsed count is strictly greater than `min_gap` raises `mig_req` in the next cycle, with `stop` low.
- R4: In the running mode, an over-limit sample taken while the elapsed count is at most `min_gap` raises `stop` in the next cycle and schedules a migration. `mig_req` stays low.
- R5: While a migration is scheduled, each valid sample sets `stop` for the following period: high if the sample is over the limit, low otherwise. The migration stays scheduled in both cases.
- R6: A scheduled migration raises `mig_req` in the cycle after the elapsed count is at least `min_gap`, whatever the temperature. `stop` falls in that same cycle.
- R7: `mig_req` stays high until `mig_done` is seen. In the cycle after that, `mig_req` and `stop` are low and the elapsed count restarts from zero. `mig_req` and `stop` are never high together.
- R8: The elapsed count advances only in cycles where `tick` is high. It saturates at 2^CW-1 and does not wrap.
- R9: Samples that arrive while a migration is in progress have no effect. A `mig_done` that arrives while no migration is in progress is ignored and does not clear the elapsed count.
- R10: A rising edge of `mig_req` only happens when the elapsed count in the preceding cycle was at least `min_gap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One core cycle has elapsed |
| smp_valid | input | 1 | Temperature sample strobe |
| smp_temp | input | TW | Temperature sample |
| temp_limit | input | TW | Over-temperature threshold |
| min_gap | input | CW | Minimum migration interval in ticks |
| mig_done | input | 1 | Sequencer reports the migration is complete |
| mig_req | output | 1 | Migration request, held until acknowledged |
| stop | output | 1 | Throttle: core in low-power stop state |

## Verification
The assertions assume that `temp_limit` and `min_gap` are stable during the cycle in which a sample is judged. They also assume the sequencer acknowledges a request with `mig_done` and does nothing else that counts. The random stimulus changes `min_gap` only at coarse intervals and keeps the limit fixed. It issues `mig_done` mostly while a request is pending, and sends a few stray acknowledgements and samples on purpose to exercise the ignore rules. Sample temperatures cluster around the limit, including the exact limit value, so that both the immediate and the scheduled paths occur often.

// File: rtl/thermtrig_pkg.sv
package thermtrig_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_MOVE = 2'd2
    } trig_mode_e;

    typedef struct packed {
        trig_mode_e mode;
        logic       stop;
    } trig_state_t;

endpackage

// File: rtl/thermtrig_overlimit.sv
module thermtrig_overlimit #(
    parameter int TW     = 8,
    parameter bit STRICT = 1'b1
) (
    input  logic          smp_valid,
    input  logic [TW-1:0] smp_temp,
    input  logic [TW-1:0] temp_limit,
    output logic          sample,
    output logic          over
);

    assign sample = smp_valid;

    generate
        if (STRICT) begin : g_gt
            assign over = smp_valid && (smp_temp > temp_limit);
        end else begin : g_ge
            assign over = smp_valid && (smp_temp >= temp_limit);
        end
    endgenerate

endmodule

// File: rtl/thermtrig_elapsed.sv
module thermtrig_elapsed #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic [CW-1:0] min_gap,
    output logic          beyond,
    output logic          reached
);

    localparam logic [CW-1:0] EL_TOP = '1;

    logic [CW-1:0] el_d, el_q;

    always_comb begin
        el_d = el_q;
        if (clr) begin
            el_d = '0;
        end else if (tick && (el_q != EL_TOP)) begin
            el_d = el_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            el_q <= '0;
        end else begin
            el_q <= el_d;
        end
    end

    assign beyond  = (el_q > min_gap);
    assign reached = (el_q >= min_gap);

    // R7: count restarts after a completed migration
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (el_q == '0));

    // R8: without a clear the count never decreases (no wrap)
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (el_q >= $past(el_q)));

    // R8: only ticks advance the count
    assert_tick_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(el_q));

endmodule

// File: rtl/thermtrig_fsm.sv
module thermtrig_fsm
    import thermtrig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic over,
    input  logic beyond,
    input  logic reached,
    input  logic mig_done,
    output logic mig_req,
    output logic stop,
    output logic clr
);

    trig_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        clr  = 1'b0;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (over) begin
                    if (beyond) begin
                        st_d.mode = MODE_MOVE;
                        st_d.stop = 1'b0;
                    end else begin
                        st_d.mode = MODE_HOLD;
                        st_d.stop = 1'b1;
                    end
                end
            end
            MODE_HOLD: begin
                if (sample) begin
                    st_d.stop = over;
                end
                if (reached) begin
                    st_d.mode = MODE_MOVE;
                    st_d.stop = 1'b0;
                end
            end
            MODE_MOVE: begin
                if (mig_done) begin
                    st_d.mode = MODE_RUN;
                    st_d.stop = 1'b0;
                    clr       = 1'b1;
                end
            end
            default: begin
                st_d.mode = MODE_RUN;
                st_d.stop = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RUN;
            st_q.stop <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mig_req = (st_q.mode == MODE_MOVE);
    assign stop    = st_q.stop;

    // R2: quiet sample in running mode leaves everything low
    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RUN && !over) |=> (!mig_req && !stop));

    // R3: late enough over-limit sample migrates at once
    assert_fast_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RUN && over && beyond) |=> (mig_req && !stop));

    // R4: too early over-limit sample throttles
    assert_throttle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RUN && over && !beyond) |=> (stop && !mig_req));

    // R7: request held until acknowledged
    assert_hold_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mig_req && !mig_done) |=> mig_req);

    // R7: acknowledgement releases request and throttle
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mig_req && mig_done) |=> (!mig_req && !stop));

    // R7: never throttle during a migration
    assert_no_stop_in_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mig_req && stop));

endmodule

// File: rtl/mig_thermal_trigger.sv
module mig_thermal_trigger #(
    parameter int TW     = 8,
    parameter int CW     = 24,
    parameter bit STRICT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          smp_valid,
    input  logic [TW-1:0] smp_temp,
    input  logic [TW-1:0] temp_limit,
    input  logic [CW-1:0] min_gap,
    input  logic          mig_done,
    output logic          mig_req,
    output logic          stop
);

    logic sample, over, beyond, reached, clr;

    thermtrig_overlimit #(
        .TW     (TW),
        .STRICT (STRICT)
    ) u_overlimit (
        .smp_valid  (smp_valid),
        .smp_temp   (smp_temp),
        .temp_limit (temp_limit),
        .sample     (sample),
        .over       (over)
    );

    thermtrig_elapsed #(
        .CW (CW)
    ) u_elapsed (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr     (clr),
        .min_gap (min_gap),
        .beyond  (beyond),
        .reached (reached)
    );

    thermtrig_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .over     (over),
        .beyond   (beyond),
        .reached  (reached),
        .mig_done (mig_done),
        .mig_req  (mig_req),
        .stop     (stop),
        .clr      (clr)
    );

    // R10: a new request only after the minimum interval
    assert_min_interval_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mig_req) |-> $past(reached));

    // R6: scheduled migration drops the throttle as it fires
    assert_fire_clears_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mig_req) |-> !stop);

endmodule

// File: tb/mig_thermal_trigger_bench.sv
module mig_thermal_trigger_bench;

    localparam int TW    = 8;
    localparam int CW    = 10;
    localparam int MAXEL = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          smp_valid = 1'b0;
    logic          mig_done = 1'b0;
    logic [TW-1:0] smp_temp = '0;
    logic [TW-1:0] temp_limit = 8'd90;
    logic [CW-1:0] min_gap = '0;
    logic          mig_req, stop;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int m_mode = 0;
    int m_el   = 0;
    bit m_stop = 1'b0;

    always #2 clk = ~clk;

    mig_thermal_trigger #(.TW(TW), .CW(CW)) u_mig_thermal_trigger (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .smp_valid  (smp_valid),
        .smp_temp   (smp_temp),
        .temp_limit (temp_limit),
        .min_gap    (min_gap),
        .mig_done   (mig_done),
        .mig_req    (mig_req),
        .stop       (stop)
    );

    function automatic void model_step(bit tk, bit sv, int tp, bit dn);
        bit over = sv && (tp > int'(temp_limit));
        bit clr  = 1'b0;
        int gap  = int'(min_gap);
        case (m_mode)
            0: if (over) begin
                   if (m_el > gap) begin m_mode = 2; m_stop = 1'b0; end
                   else begin m_mode = 1; m_stop = 1'b1; end
               end
            1: begin
                   if (sv) m_stop = over;
                   if (m_el >= gap) begin m_mode = 2; m_stop = 1'b0; end
               end
            default: if (dn) begin m_mode = 0; m_stop = 1'b0; clr = 1'b1; end
        endcase
        if (clr) m_el = 0;
        else if (tk && m_el != MAXEL) m_el = m_el + 1;
    endfunction

    task automatic check(string tag);
        bit exp_req = (m_mode == 2);
        checks++;
        if (mig_req !== exp_req || stop !== m_stop) begin
            errors++;
            $display("FAIL %s: mig_req=%b stop=%b expected mig_req=%b stop=%b at %0t",
                     tag, mig_req, stop, exp_req, m_stop, $time);
        end
    endtask

    task automatic step(bit tk, bit sv, int tp, bit dn, string tag);
        @(negedge clk);
        tick = tk; smp_valid = sv; smp_temp = tp[TW-1:0]; mig_done = dn;
        @(posedge clk);
        model_step(tk, sv, tp, dn);
        #1;
        check(tag);
    endtask

    task automatic finish_move(string tag);
        while (m_mode == 2) step(0, 0, 0, 1, tag);
        step(0, 0, 0, 0, tag);
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1");

        // R1: elapsed is zero after reset, so gap 0 cannot fire at once
        min_gap = '0;
        step(0, 1, 95, 0, "R1");
        step(0, 0, 0, 0, "R1");
        finish_move("R1");

        // R2: samples at or below the limit
        min_gap = 10'd30;
        for (int i = 0; i < 100; i++)
            step(1, (i % 8) == 0, 60 + (i % 31), 0, "R2");
        step(1, 1, 90, 0, "R2");

        // R3 then R7: immediate request, held, released
        step(1, 1, 95, 0, "R3");
        repeat (5) step(1, 0, 0, 0, "R7");
        step(0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, "R7");

        // R4, R5, R6: throttle, extend, drop, scheduled fire
        step(1, 1, 91, 0, "R4");
        repeat (7) step(1, 0, 0, 0, "R5");
        step(1, 1, 99, 0, "R5");
        repeat (7) step(1, 0, 0, 0, "R5");
        step(1, 1, 50, 0, "R5");
        repeat (20) step(1, 0, 0, 0, "R6");
        finish_move("R7");

        // R8: only ticks advance the count
        min_gap = 10'd5;
        repeat (40) step(0, 0, 0, 0, "R8");
        step(0, 1, 95, 0, "R8");
        repeat (10) step(0, 0, 0, 0, "R8");
        repeat (6) step(1, 0, 0, 0, "R8");
        finish_move("R8");

        // R8: saturation at the top value
        min_gap = 10'(MAXEL);
        repeat (1100) step(1, 0, 0, 0, "R8");
        step(1, 1, 95, 0, "R8");
        repeat (3) step(1, 0, 0, 0, "R8");
        finish_move("R8");

        // R9: stray acknowledgement and samples during migration
        min_gap = 10'd20;
        repeat (30) step(1, 0, 0, 0, "R9");
        step(0, 0, 0, 1, "R9");
        step(0, 1, 95, 0, "R9");
        step(1, 1, 99, 0, "R9");
        step(1, 1, 10, 0, "R9");
        finish_move("R9");

        // R10: random traffic
        for (int i = 0; i < 20000; i++) begin
            bit tk, sv, dn;
            int tp;
            if ((i % 500) == 0) min_gap = 10'(10 + ($urandom % 80));
            tk = ($urandom % 2) == 0;
            sv = (i % 8) == 3;
            tp = 84 + int'($urandom % 13);
            if (m_mode == 2) dn = ($urandom % 4) == 0;
            else             dn = ($urandom % 64) == 0;
            step(tk, sv, tp, dn, "R10");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule